// File: doc/BRIEF.md
# Waited-Transfer Protocol Monitor

This block is a passive observer for a pipelined address/data bus in which a subordinate stretches a data phase by holding the ready line low. While a data phase is stretched, the manager may still alter the pending address phase, but only in a few narrow ways. The monitor records the previous cycle's transfer type, address, burst class, ready and response. Whenever the previous cycle was a wait cycle, it judges the current cycle against those records. Each broken rule raises its own sticky flag, and a combined sticky error line summarises them.

The monitor also emits a stream of accepted transfers: one `acc_valid` beat, carrying the accepted address, for every real transfer the bus took. The stream is valid-only. A passive observer cannot stall the bus, so there is no back-pressure, and a consumer must take each beat in the cycle it appears. The monitor drives nothing onto the bus. It is instantiated next to a manager port in a design or a bench, with its flags routed to an interrupt or a test log.

Top module: `wt_monitor`

## Requirements
- R1: While `rst_n` is low and after its release, `rule_flags`, `err_any` and `acc_valid` are 0.
- R2: A cycle sampled with `bus_ready`=1 and `bus_trans` of 2'b10 (start) or 2'b11 (continue) produces `acc_valid`=1 with `acc_addr` equal to that cycle's address, one cycle later. Idle (2'b00), pause (2'b01) or any cycle with `bus_ready`=0 produces no beat.
- R3: After a wait cycle that carried idle (2'b00), the address may change freely, and the type may stay idle or become start (2'b10). A change to pause or continue sets `rule_flags[0]`.
- R4: After a wait cycle that carried start or continue, any change of type or address sets `rule_flags[1]`, unless R7 applies.
- R5: After a wait cycle that carried pause inside a fixed-length burst (`bus_burst` not 3'b001), the type must stay pause or become continue. Anything else sets `rule_flags[2]`, unless R7 applies.
- R6: After a wait cycle that carried pause inside an open-length burst (`bus_burst`=3'b001), a change to continue, idle or start raises no flag.
- R7: If the previous cycle had `bus_resp`=1 with `bus_ready`=0, a current idle cycle is exempt from all rules whatever its address.
- R8: Outside idle-type waits and the R7 exemption, at most `CHG_LIMIT` (default 1) address changes are allowed within one stretch of wait cycles. The next change sets `rule_flags[3]`.
- R9: No rule is applied in the first sampled cycle after reset, or to a cycle whose predecessor had `bus_ready`=1.
- R10: Each flag bit stays set until reset. `err_any` is 1 exactly when some bit of `rule_flags` is 1. Flags appear one cycle after the offending cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_trans | input | 2 | Transfer type: 00 idle, 01 pause, 10 start, 11 continue |
| bus_addr | input | AW | Address phase address |
| bus_burst | input | 3 | Burst class; 3'b001 means open length |
| bus_ready | input | 1 | Data phase completes when high |
| bus_resp | input | 1 | Error response indication |
| acc_valid | output | 1 | One beat per accepted real transfer |
| acc_addr | output | AW | Address of the accepted transfer |
| rule_flags | output | 4 | Sticky per-rule violation flags (bit 0 idle, 1 hold, 2 pause, 3 address count) |
| err_any | output | 1 | Sticky combined violation |

## Verification
A corrupted history register shows up as a false or missing flag one cycle after the first wait cycle that follows it. A stuck validity bit appears on the very first sampled cycle after reset. A wrong address-change count only appears on the second change within one wait stretch. It can stay hidden until a pause sequence moves its address twice. Faults in the accept path are visible at once as a missing or surplus beat, or a wrong address, in the cycle after a ready-high real transfer.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic [1:0] {
    TR_IDLE  = 2'b00,
    TR_PAUSE = 2'b01,
    TR_START = 2'b10,
    TR_CONT  = 2'b11
  } tr_e;

  localparam logic [2:0] BURST_OPEN = 3'b001;

  localparam int NRULE     = 4;
  localparam int RULE_IDLE = 0;
  localparam int RULE_HOLD = 1;
  localparam int RULE_BUSY = 2;
  localparam int RULE_ADDR = 3;

  typedef struct packed {
    logic [1:0] trans;
    logic       open_len;
    logic       ready;
    logic       err_first;
    logic       valid;
  } hist_t;
endpackage

// File: rtl/wt_history.sv
module wt_history
  import wt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    trans,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    burst,
  input  logic          ready,
  input  logic          resp,
  output hist_t         hist,
  output logic [AW-1:0] hist_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist      <= '0;
      hist_addr <= '0;
    end else begin
      hist.trans     <= trans;
      hist.open_len  <= (burst == BURST_OPEN);
      hist.ready     <= ready;
      hist.err_first <= resp & ~ready;
      hist.valid     <= 1'b1;
      hist_addr      <= addr;
    end
  end
endmodule

// File: rtl/wt_rules.sv
module wt_rules
  import wt_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CHG_LIMIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       trans,
  input  logic [AW-1:0]    addr,
  input  logic             ready,
  input  hist_t            hist,
  input  logic [AW-1:0]    hist_addr,
  output logic [NRULE-1:0] viol
);
  localparam int CW = $clog2(CHG_LIMIT + 2);
  localparam logic [CW-1:0] CNT_MAX = CW'(CHG_LIMIT);

  logic          cmp_en;
  logic          addr_chg;
  logic          type_chg;
  logic          exempt;
  logic          counted;
  logic [CW-1:0] chg_cnt;

  always_comb begin
    cmp_en   = hist.valid & ~hist.ready;
    addr_chg = (addr != hist_addr);
    type_chg = (trans != hist.trans);
    exempt   = hist.err_first && (trans == TR_IDLE);
    counted  = cmp_en && !exempt && (hist.trans != TR_IDLE) && addr_chg;
    viol     = '0;
    if (cmp_en && !exempt) begin
      case (hist.trans)
        TR_IDLE:  viol[RULE_IDLE] = (trans == TR_PAUSE) || (trans == TR_CONT);
        TR_PAUSE: viol[RULE_BUSY] = !hist.open_len &&
                                    !((trans == TR_PAUSE) || (trans == TR_CONT));
        default:  viol[RULE_HOLD] = type_chg || addr_chg;
      endcase
    end
    viol[RULE_ADDR] = counted && (chg_cnt >= CNT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_cnt <= '0;
    end else if (ready) begin
      chg_cnt <= '0;
    end else if (counted && (chg_cnt < CNT_MAX)) begin
      chg_cnt <= chg_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wt_flags.sv
module wt_flags
  import wt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NRULE-1:0] viol,
  output logic [NRULE-1:0] rule_flags,
  output logic             err_any
);
  for (genvar i = 0; i < NRULE; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rule_flags[i] <= 1'b0;
      else if (viol[i]) rule_flags[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_any <= 1'b0;
    else if (|viol) err_any <= 1'b1;
  end
endmodule

// File: rtl/wt_accept.sv
module wt_accept #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    trans,
  input  logic [AW-1:0] addr,
  input  logic          ready,
  output logic          acc_valid,
  output logic [AW-1:0] acc_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_addr  <= '0;
    end else begin
      acc_valid <= ready & trans[1];
      if (ready && trans[1]) acc_addr <= addr;
    end
  end
endmodule

// File: rtl/wt_monitor.sv
module wt_monitor
  import wt_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CHG_LIMIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_trans,
  input  logic [AW-1:0] bus_addr,
  input  logic [2:0]    bus_burst,
  input  logic          bus_ready,
  input  logic          bus_resp,
  output logic          acc_valid,
  output logic [AW-1:0] acc_addr,
  output logic [3:0]    rule_flags,
  output logic          err_any
);
  hist_t             hist;
  logic [AW-1:0]     hist_addr;
  logic [NRULE-1:0]  viol;

  wt_history #(.AW(AW)) u_hist (
    .clk(clk), .rst_n(rst_n), .trans(bus_trans), .addr(bus_addr),
    .burst(bus_burst), .ready(bus_ready), .resp(bus_resp),
    .hist(hist), .hist_addr(hist_addr)
  );

  wt_rules #(.AW(AW), .CHG_LIMIT(CHG_LIMIT)) u_rules (
    .clk(clk), .rst_n(rst_n), .trans(bus_trans), .addr(bus_addr),
    .ready(bus_ready), .hist(hist), .hist_addr(hist_addr), .viol(viol)
  );

  wt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .viol(viol),
    .rule_flags(rule_flags), .err_any(err_any)
  );

  wt_accept #(.AW(AW)) u_acc (
    .clk(clk), .rst_n(rst_n), .trans(bus_trans), .addr(bus_addr),
    .ready(bus_ready), .acc_valid(acc_valid), .acc_addr(acc_addr)
  );
endmodule

// File: rtl/wt_monitor_chk.sv
module wt_monitor_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    bus_trans,
  input logic [AW-1:0] bus_addr,
  input logic [2:0]    bus_burst,
  input logic          bus_ready,
  input logic          bus_resp,
  input logic          acc_valid,
  input logic [AW-1:0] acc_addr,
  input logic [3:0]    rule_flags,
  input logic          err_any
);
  p_acc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && bus_trans[1]) |=> (acc_valid && acc_addr == $past(bus_addr)));

  p_noacc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ready && bus_trans[1]) |=> !acc_valid);

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ready && bus_trans == 2'b00) ##1 (bus_trans == 2'b01 || bus_trans == 2'b11)
    |=> rule_flags[0]);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ready && bus_trans[1]) ##1
    ((bus_trans != $past(bus_trans) || bus_addr != $past(bus_addr)) &&
     !($past(bus_resp) && bus_trans == 2'b00))
    |=> rule_flags[1]);

  p_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ready && bus_trans == 2'b01 && bus_burst != 3'b001) ##1
    (bus_trans[0] == 1'b0 && !($past(bus_resp) && bus_trans == 2'b00))
    |=> rule_flags[2]);

  p_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_resp && !bus_ready) ##1 (bus_trans == 2'b00) |=> $stable(rule_flags));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |=> (err_any && ((rule_flags & $past(rule_flags)) == $past(rule_flags))));

  p_any_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_any == (rule_flags != 4'b0));
endmodule

bind wt_monitor wt_monitor_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_trans(bus_trans), .bus_addr(bus_addr),
  .bus_burst(bus_burst), .bus_ready(bus_ready), .bus_resp(bus_resp),
  .acc_valid(acc_valid), .acc_addr(acc_addr), .rule_flags(rule_flags),
  .err_any(err_any)
);

// File: tb/wt_monitor_bench.sv
module wt_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    bus_trans = 2'b00;
  logic [AW-1:0] bus_addr = '0;
  logic [2:0]    bus_burst = 3'b000;
  logic          bus_ready = 1'b1;
  logic          bus_resp = 1'b0;
  logic          acc_valid;
  logic [AW-1:0] acc_addr;
  logic [3:0]    rule_flags;
  logic          err_any;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wt_monitor #(.AW(AW)) u_wt_monitor (
    .clk(clk), .rst_n(rst_n), .bus_trans(bus_trans), .bus_addr(bus_addr),
    .bus_burst(bus_burst), .bus_ready(bus_ready), .bus_resp(bus_resp),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .rule_flags(rule_flags),
    .err_any(err_any)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] t, input logic [AW-1:0] a, input logic [2:0] b,
                       input logic r, input logic e);
    @(negedge clk);
    bus_trans = t; bus_addr = a; bus_burst = b; bus_ready = r; bus_resp = e;
    if (r && t[1] && rst_n) exp_q.push_back(a);
  endtask

  task automatic flags_are(input string req, input logic [3:0] exp);
    drive(2'b00, '0, 3'b000, 1'b1, 1'b0);
    @(negedge clk);
    check(req, AW'(rule_flags), AW'(exp));
    check({req, " any"}, AW'(err_any), AW'(exp != 4'b0));
    check({req, " queue"}, AW'(exp_q.size()), '0);
  endtask

  task automatic do_reset();
    drive(2'b00, '0, 3'b000, 1'b1, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  // monitor: pops expected accepted addresses
  always @(negedge clk) begin
    if (rst_n && acc_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: actual beat %0h expected none", acc_addr);
      end else begin
        logic [AW-1:0] e;
        e = exp_q.pop_front();
        if (acc_addr !== e) begin
          errors++;
          $display("FAIL R2: actual %0h expected %0h", acc_addr, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 flags in reset", AW'(rule_flags), '0);
    check("R1 acc in reset", AW'(acc_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flags after release", AW'({err_any, rule_flags}), '0);

    // R2 / R9: accept stream, changes after ready-high cycles are free
    drive(2'b10, 32'h1000, 3'b001, 1'b1, 1'b0);
    drive(2'b11, 32'h1004, 3'b001, 1'b1, 1'b0);
    drive(2'b01, 32'h1008, 3'b001, 1'b1, 1'b0);
    drive(2'b11, 32'h1008, 3'b001, 1'b0, 1'b0);
    drive(2'b11, 32'h1008, 3'b001, 1'b1, 1'b0);
    flags_are("R2 R9 stream", 4'b0000);

    // R3 legal idle wait with address changes then start
    do_reset();
    drive(2'b10, 32'h0A00, 3'b000, 1'b1, 1'b0);
    drive(2'b00, 32'h0B00, 3'b000, 1'b0, 1'b0);
    drive(2'b00, 32'h0C00, 3'b000, 1'b0, 1'b0);
    drive(2'b10, 32'h0D00, 3'b011, 1'b0, 1'b0);
    drive(2'b10, 32'h0D00, 3'b011, 1'b0, 1'b0);
    drive(2'b10, 32'h0D00, 3'b011, 1'b1, 1'b0);
    drive(2'b11, 32'h0D04, 3'b011, 1'b1, 1'b0);
    flags_are("R3 R8 legal idle", 4'b0000);

    // R3 illegal idle to continue
    do_reset();
    drive(2'b00, 32'h0E00, 3'b000, 1'b0, 1'b0);
    drive(2'b11, 32'h0E00, 3'b011, 1'b1, 1'b0);
    flags_are("R3 idle to continue", 4'b0001);

    // R4 address moved while start held
    do_reset();
    drive(2'b10, 32'h2000, 3'b000, 1'b0, 1'b0);
    drive(2'b10, 32'h2008, 3'b000, 1'b0, 1'b0);
    drive(2'b10, 32'h2008, 3'b000, 1'b1, 1'b0);
    flags_are("R4 addr change", 4'b0010);
    repeat (3) @(negedge clk);
    check("R10 sticky", AW'({err_any, rule_flags}), AW'(5'b10010));

    // R4 type change while continue held
    do_reset();
    drive(2'b11, 32'h2100, 3'b011, 1'b0, 1'b0);
    drive(2'b10, 32'h2100, 3'b011, 1'b0, 1'b0);
    drive(2'b10, 32'h2100, 3'b011, 1'b1, 1'b0);
    flags_are("R4 type change", 4'b0010);

    // R5 fixed burst pause: legal to continue, illegal to idle
    do_reset();
    drive(2'b01, 32'h0028, 3'b011, 1'b0, 1'b0);
    drive(2'b01, 32'h0028, 3'b011, 1'b0, 1'b0);
    drive(2'b11, 32'h0028, 3'b011, 1'b0, 1'b0);
    drive(2'b11, 32'h0028, 3'b011, 1'b1, 1'b0);
    flags_are("R5 pause to continue", 4'b0000);
    drive(2'b01, 32'h002C, 3'b011, 1'b0, 1'b0);
    drive(2'b00, 32'h002C, 3'b011, 1'b0, 1'b0);
    flags_are("R5 pause to idle", 4'b0100);

    // R6 open-length pause ends with start or idle
    do_reset();
    drive(2'b01, 32'h0068, 3'b001, 1'b0, 1'b0);
    drive(2'b10, 32'h0010, 3'b001, 1'b0, 1'b0);
    drive(2'b10, 32'h0010, 3'b001, 1'b1, 1'b0);
    drive(2'b01, 32'h0014, 3'b001, 1'b0, 1'b0);
    drive(2'b00, 32'h0014, 3'b001, 1'b0, 1'b0);
    flags_are("R6 open pause", 4'b0000);

    // R7 error exemption, then the same move without error
    do_reset();
    drive(2'b11, 32'h0028, 3'b011, 1'b0, 1'b1);
    drive(2'b00, 32'h00C0, 3'b000, 1'b0, 1'b1);
    drive(2'b00, 32'h00C0, 3'b000, 1'b1, 1'b0);
    flags_are("R7 error cancel", 4'b0000);
    drive(2'b11, 32'h0028, 3'b011, 1'b0, 1'b0);
    drive(2'b00, 32'h00C0, 3'b000, 1'b0, 1'b0);
    flags_are("R7 no error", 4'b0010);

    // R8 two address changes in one wait
    do_reset();
    drive(2'b01, 32'h0040, 3'b001, 1'b0, 1'b0);
    drive(2'b01, 32'h0044, 3'b001, 1'b0, 1'b0);
    drive(2'b01, 32'h0048, 3'b001, 1'b0, 1'b0);
    drive(2'b01, 32'h0048, 3'b001, 1'b1, 1'b0);
    flags_are("R8 second change", 4'b1000);

    // R9 first sampled cycle after reset is not compared
    drive(2'b00, '0, 3'b000, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    bus_trans = 2'b11; bus_addr = 32'h0104; bus_burst = 3'b011; bus_ready = 1'b0;
    drive(2'b11, 32'h0104, 3'b011, 1'b1, 1'b0);
    flags_are("R9 first cycle", 4'b0000);

    finish_run();
  end
endmodule